// File: doc/BRIEF.md
# Fully Associative Tag Directory

This block is the tag side of a small fully associative cache. Every entry stores one block tag and a valid flag. A looked-up address is reduced to its tag, and that tag is compared with all entries in the same cycle, one comparator per entry. Each comparison counts only if the entry's valid flag is set. One clock later the block reports whether the tag was present and which entry holds it. Data storage, the engine that fetches blocks from memory and the write policy belong to the surrounding cache.

With every lookup the block also names a victim entry, the slot the cache controller should refill if the lookup missed. While any entry is still empty, the victim is the lowest-numbered empty entry. Once the directory is full, the victim is the entry under a single rotating pointer. This is a cheap stand-in for least-recently-used order. The pointer steps forward only when the entry it names is touched, either by a lookup hit or by a refill. So a block that is in active use moves out from under the pointer instead of being evicted. The controller writes a new tag through the fill port, using the entry index it chose.

With the default parameters there are 64 entries, 32-bit addresses and 32-byte blocks. The offset is the low 5 address bits and the tag is the upper 27 bits. There is no index field.

Top module: `fa_tag_dir`

## Requirements
- R1: A synchronous reset marks every entry invalid, returns the replacement pointer to entry 0, and drives `res_valid` and `res_hit` low.
- R2: The tag is address bits [31:5]. Two addresses that differ only in bits [4:0] find the same entry.
- R3: A lookup presented in one cycle gives its result in the next cycle: `res_valid` high, `res_hit` high if a valid entry holds the tag, and `res_idx` equal to the number of that entry. At most one entry holds a given tag.
- R4: An entry whose valid flag is clear never produces a hit, whatever its stored tag bits are.
- R5: If any entry is invalid, `res_victim` is the lowest-numbered invalid entry.
- R6: If all entries are valid, `res_victim` is the entry under the replacement pointer, taken before that lookup's own pointer update.
- R7: A lookup hit on the entry under the pointer moves the pointer forward by one entry. From entry 63 it moves to entry 0.
- R8: A miss, or a hit on any entry other than the one under the pointer, leaves the pointer where it is.
- R9: A fill writes the tag of `fill_addr` into entry `fill_idx` and marks that entry valid. A fill into the entry under the pointer moves the pointer forward by one; a fill into any other entry does not move it.
- R10: When a lookup and a fill occur in the same cycle, the lookup is compared against the directory contents from before that fill.
- R11: In the cycle after a cycle with no lookup request, `res_valid` and `res_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_addr | input | 32 | Address to look up |
| fill_en | input | 1 | Fill strobe |
| fill_idx | input | 6 | Entry to write on a fill |
| fill_addr | input | 32 | Address whose tag is stored on a fill |
| res_valid | output | 1 | Lookup result present (registered) |
| res_hit | output | 1 | Lookup found a valid matching entry |
| res_idx | output | 6 | Matching entry, meaningful when `res_hit` is high |
| res_victim | output | 6 | Entry nominated for replacement |

## Verification
The single-match assertion assumes the controller never fills a tag that is already valid in another entry. Every fill in the stimulus therefore uses a tag that is not present in the directory, or replaces the tag in the very entry being written. The pointer assertions assume `fill_idx` is always a legal entry number, which holds because the width exactly covers the 64 entries. All pointer movement is observed only through `res_victim` once the directory is full, so the stimulus fills every entry before it tests how the pointer moves.

// File: rtl/fa_dir_pkg.sv
package fa_dir_pkg;
  // Default geometry shared by the directory modules.
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_BLK_B    = 32;
  localparam int unsigned DEF_ENTRIES  = 64;

  // Step a wrapping entry pointer.
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned n);
    return (cur == n - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/fa_tag_array.sv
module fa_tag_array #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned TAG_W   = 27,
  parameter int unsigned IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmp_en,
  input  logic [TAG_W-1:0]   cmp_tag,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(e));

    // Tag storage has no reset; the valid flag guards it.
    always_ff @(posedge clk) begin
      if (sel) tag_q[e] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (rst)      valid_q[e] <= 1'b0;
      else if (sel) valid_q[e] <= 1'b1;
    end

    // One comparator per entry, qualified by valid (R4).
    assign match_vec[e] = valid_q[e] && (tag_q[e] == cmp_tag);
  end

  assign valid_vec = valid_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (valid_q == '0));

  assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
    cmp_en |-> $onehot0(match_vec));

  assert_fill_sets_valid_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/fa_repl_ptr.sv
module fa_repl_ptr #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  output logic [IDX_W-1:0] ptr
);
  import fa_dir_pkg::*;

  logic [IDX_W-1:0] ptr_q;
  logic             touch_hit;
  logic             touch_fill;
  logic             advance;
  logic [IDX_W-1:0] ptr_nxt;

  assign touch_hit  = hit_en  && (hit_idx  == ptr_q);
  assign touch_fill = fill_en && (fill_idx == ptr_q);
  assign advance    = touch_hit || touch_fill;
  assign ptr_nxt    = IDX_W'(wrap_next(int'(ptr_q), ENTRIES));

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (advance) ptr_q <= ptr_nxt;
  end

  assign ptr = ptr_q;

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!(hit_en && hit_idx == ptr_q) && !(fill_en && fill_idx == ptr_q)) |=> $stable(ptr_q));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (hit_en && hit_idx == ptr_q) |=>
      (ptr_q == (($past(ptr_q) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ptr_q) + 1'b1)));

  assert_ptr_fill_step_R9: assert property (@(posedge clk) disable iff (rst)
    (fill_en && fill_idx == ptr_q) |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned IDX_W   = 6
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [IDX_W-1:0]   ptr,
  output logic               any_free,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] free_idx;

  // Lowest-numbered invalid entry wins (R5).
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_vec[e]) begin
        free_idx = IDX_W'(e);
        any_free = 1'b1;
      end
    end
  end

  assign victim = any_free ? free_idx : ptr;
endmodule

// File: rtl/fa_tag_dir.sv
module fa_tag_dir #(
  parameter int unsigned ADDR_W  = fa_dir_pkg::DEF_ADDR_W,
  parameter int unsigned BLK_B   = fa_dir_pkg::DEF_BLK_B,
  parameter int unsigned ENTRIES = fa_dir_pkg::DEF_ENTRIES,
  localparam int unsigned OFFS_W = $clog2(BLK_B),
  localparam int unsigned TAG_W  = ADDR_W - OFFS_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx,
  output logic [IDX_W-1:0]  res_victim
);
  logic [TAG_W-1:0]   lkp_tag;
  logic [TAG_W-1:0]   fill_tag;
  logic               unused_offset_bits;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic               hit_c;
  logic [IDX_W-1:0]   hit_idx_c;
  logic [IDX_W-1:0]   ptr;
  logic               any_free;
  logic [IDX_W-1:0]   victim_c;

  // Offset bits do not take part in the match (R2).
  assign lkp_tag  = lkp_addr[ADDR_W-1:OFFS_W];
  assign fill_tag = fill_addr[ADDR_W-1:OFFS_W];
  assign unused_offset_bits = ^{lkp_addr[OFFS_W-1:0], fill_addr[OFFS_W-1:0]};

  fa_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .cmp_en   (lkp_valid),
    .cmp_tag  (lkp_tag),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_tag   (fill_tag),
    .match_vec(match_vec),
    .valid_vec(valid_vec)
  );

  // The match vector is one-hot at most, so OR-encoding is sufficient.
  always_comb begin
    hit_idx_c = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match_vec[e]) hit_idx_c = hit_idx_c | IDX_W'(e);
    end
  end
  assign hit_c = |match_vec;

  fa_repl_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .hit_en  (lkp_valid && hit_c),
    .hit_idx (hit_idx_c),
    .fill_en (fill_en),
    .fill_idx(fill_idx),
    .ptr     (ptr)
  );

  fa_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_vec(valid_vec),
    .ptr      (ptr),
    .any_free (any_free),
    .victim   (victim_c)
  );

  // Registered result stage (R3).
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_idx    <= '0;
      res_victim <= '0;
    end else begin
      res_valid  <= lkp_valid;
      res_hit    <= lkp_valid && hit_c;
      res_idx    <= hit_idx_c;
      res_victim <= victim_c;
    end
  end

  assert_victim_free_R5: assert property (@(posedge clk) disable iff (rst)
    any_free |-> !valid_vec[victim_c]);

  assert_victim_ptr_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_vec == '1) |-> (victim_c == ptr));

  assert_res_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && hit_c) |=> (res_valid && res_hit));

  assert_res_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> (!res_valid && !res_hit));
endmodule

// File: tb/test_fa_tag_dir.sv
`timescale 1ns/1ps
module test_fa_tag_dir;
  localparam int N = 64;

  typedef struct packed {
    logic        is_fill;
    logic [31:0] addr;
    logic [5:0]  idx;
    logic        hit;
    logic [5:0]  vic;
  } vec_t;

  // Walked once all 64 entries are valid and the pointer sits at entry 0.
  localparam vec_t TBL [11] = '{
    '{1'b0, 32'hA000_051F, 6'd5,  1'b1, 6'd0},  // R2 offset ignored, R8 no move
    '{1'b0, 32'h5555_0000, 6'd0,  1'b0, 6'd0},  // R6 miss victim = pointer
    '{1'b0, 32'hA000_0000, 6'd0,  1'b1, 6'd0},  // R7 hit under pointer
    '{1'b0, 32'h5555_0000, 6'd0,  1'b0, 6'd1},  // R7 pointer moved
    '{1'b1, 32'h7777_0020, 6'd1,  1'b0, 6'd0},  // R9 fill at pointer
    '{1'b0, 32'h7777_0020, 6'd1,  1'b1, 6'd2},  // R9 new tag, pointer moved
    '{1'b0, 32'hA000_0100, 6'd0,  1'b0, 6'd2},  // R9 old tag gone
    '{1'b1, 32'h8888_0040, 6'd7,  1'b0, 6'd0},  // R9 fill elsewhere
    '{1'b0, 32'h5555_0000, 6'd0,  1'b0, 6'd2},  // R9 pointer unchanged
    '{1'b0, 32'h8888_005F, 6'd7,  1'b1, 6'd2},  // R3 hit index
    '{1'b0, 32'hA000_3F00, 6'd63, 1'b1, 6'd2}   // R8 hit elsewhere
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_addr = '0;
  logic        fill_en = 1'b0;
  logic [5:0]  fill_idx = '0;
  logic [31:0] fill_addr = '0;
  logic        res_valid;
  logic        res_hit;
  logic [5:0]  res_idx;
  logic [5:0]  res_victim;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fa_tag_dir i_fa_tag_dir (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_addr(fill_addr),
    .res_valid(res_valid), .res_hit(res_hit),
    .res_idx(res_idx), .res_victim(res_victim)
  );

  function automatic logic [31:0] base_addr(input int e);
    return 32'hA000_0000 | (32'(e) << 8);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive one cycle, then sample at the next falling edge.
  task automatic step(input logic lk, input logic [31:0] la,
                      input logic fe, input logic [5:0] fi, input logic [31:0] fa);
    lkp_valid = lk; lkp_addr = la;
    fill_en = fe; fill_idx = fi; fill_addr = fa;
    @(negedge clk);
    lkp_valid = 1'b0; fill_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] a,
                      input logic hit, input logic [5:0] idx, input logic [5:0] vic);
    step(1'b1, a, 1'b0, 6'd0, 32'd0);
    chk({req, " res_valid"}, 32'(res_valid), 32'd1);
    chk({req, " res_hit"}, 32'(res_hit), 32'(hit));
    if (hit) chk({req, " res_idx"}, 32'(res_idx), 32'(idx));
    chk({req, " res_victim"}, 32'(res_victim), 32'(vic));
  endtask

  task automatic fill(input logic [5:0] i, input logic [31:0] a);
    step(1'b0, 32'd0, 1'b1, i, a);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state at the outputs.
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
    chk("R1 res_hit after reset", 32'(res_hit), 32'd0);
    // R4: stored tag bits are unknown or zero, entry invalid must not hit.
    look("R4 invalid no hit", 32'h0000_0000, 1'b0, 6'd0, 6'd0);
    // R11 idle cycle.
    step(1'b0, 32'd0, 1'b0, 6'd0, 32'd0);
    chk("R11 res_valid idle", 32'(res_valid), 32'd0);
    chk("R11 res_hit idle", 32'(res_hit), 32'd0);

    // R5: victim is the lowest empty entry while filling in order.
    for (int e = 0; e < N; e++) begin
      look("R5 fill phase", base_addr(e), 1'b0, 6'd0, 6'(e));
      fill(6'(e), base_addr(e));
    end
    // R7/R9: 64 fills each under the pointer wrap it back to 0 (R6).
    look("R6 full dir victim", 32'h5555_0000, 1'b0, 6'd0, 6'd0);

    for (int k = 0; k < 11; k++) begin
      if (TBL[k].is_fill) fill(TBL[k].idx, TBL[k].addr);
      else look($sformatf("R3 table row %0d", k), TBL[k].addr, TBL[k].hit,
                TBL[k].idx, TBL[k].vic);
    end

    // R7: walk the pointer from 2 to 63 with hits, then it wraps to 0.
    for (int e = 2; e < N; e++) begin
      look("R7 pointer walk", (e == 7) ? 32'h8888_0040 : base_addr(e), 1'b1, 6'(e), 6'(e));
    end
    look("R7 wrap to 0", 32'h5555_0000, 1'b0, 6'd0, 6'd0);

    // R10: lookup and fill of the same tag in one cycle sees the old contents.
    step(1'b1, 32'h6666_0000, 1'b1, 6'd0, 32'h6666_0000);
    chk("R10 same-cycle lookup misses", 32'(res_hit), 32'd0);
    chk("R10 same-cycle victim", 32'(res_victim), 32'd0);
    look("R10 tag present next cycle", 32'h6666_0000, 1'b1, 6'd0, 6'd1);

    // R1: reset in mid-run empties the directory and rewinds the pointer.
    do_reset();
    chk("R1 res_valid after second reset", 32'(res_valid), 32'd0);
    look("R1 entries invalid after reset", 32'hA000_0500, 1'b0, 6'd0, 6'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule